// File: doc/BRIEF.md
# Special Page Region Access and Lock Controller

This block is the command-side controller for a serial NAND device's special page region. It receives already decoded commands: register writes, page loads, page programs with an address, address-less program-executes, and buffer writes and reads. While the access-enable bit of the configuration register is clear, every page command passes straight through to the main array as a one-cycle forward pulse. While the bit is set, page commands go to a small region instead. That region holds a factory ID page, a factory parameter page and `N_OTP` one-time-programmable pages.

Inside the region the block enforces the access rules. The two factory pages can only be read. A program can only clear bits in the programmable pages. Two permanent lock bits exist. A lock bit is first set in the configuration register and then committed by an address-less program-execute issued in access mode. Committing the protection-register lock also requires both protect-enable bits of the protection register to be set. Page loads, page programs and lock commits each hold BUSY for a fixed number of cycles. A refused program, lock or load raises a fail flag. The page size and the number of pages are parameters, and the default values describe a small model of the region.

Top module: `sp_region_ctrl`

## Requirements
- R1: After a synchronous reset, busy, prog_fail, rd_valid and main_valid are 0, rd_data is 0, and both registers read 0x00.
- R2: With cfg bit 0 (access enable) at 0, commands 2 (page load), 3 (program with address) and 4 (address-less program) are not executed locally. Instead main_valid is 1 for one cycle after the accepting edge, with main_op and main_addr equal to the command's op and address, and busy stays 0.
- R3: In access mode, a page load puts the page into the buffer. Address 0x00 gives word w = 0xC0+w, address 0x01 gives word w = 0xF0-w, and addresses 0x02 to 0x0B give the stored content of the programmable pages 0 to 9.
- R4: In access mode, a page load or a program to any address above 0x0B is refused: prog_fail becomes 1 and busy stays 0.
- R5: In access mode, a program to address 0x00 or 0x01 is refused (prog_fail 1, busy 0), and the page content is left unchanged.
- R6: Programmable pages start as all ones. A program stores the old word AND the buffer word, so a bit that is 0 never returns to 1.
- R7: An accepted page load, program or lock commit raises busy at the accepting edge, and busy stays 1 for exactly BUSY_CYCLES cycles.
- R8: A command presented while busy is 1 is ignored: no register changes, no rd_valid pulse and no forward pulse.
- R9: Setting cfg bit 1 and then issuing command 4 in access mode commits the programmable-page lock. After the commit, every program to 0x02 to 0x0B is refused and leaves the content unchanged, while page loads still work.
- R10: Command 4 with cfg bit 2 at 1 is refused unless protection-register bits 7 and 6 are both 1, and a refused command commits nothing. After this lock is committed, writes to the protection register (register select 0) have no effect.
- R11: Before its commit, a lock bit can be written to 0 or 1. After its commit, writing 0 to it has no effect, and it reads back as 1.
- R12: prog_fail is cleared by the next accepted command of any kind.
- R13: Command 6 (buffer read) makes rd_valid 1 for one cycle after the accepting edge, with rd_data equal to the buffer word. The word is taken at the column in cmd_addr when cfg bit 0 or cfg bit 3 is 1, and at column 0 otherwise. Command 5 writes cmd_data to the buffer at that column. Command 1 writes cmd_data to the register chosen by cmd_addr bit 0 (0 selects the protection register, 1 selects the configuration register).
- R14: In access mode, command 4 is refused when neither cfg bit 1 nor cfg bit 2 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 1 register write, 2 page load, 3 program with address, 4 address-less program, 5 buffer write, 6 buffer read |
| cmd_addr | input | PA_W | Page address, buffer column, or register select in bit 0 |
| cmd_data | input | DW | Register or buffer write data |
| busy | output | 1 | An operation is running |
| prog_fail | output | 1 | The last accepted command was refused |
| rd_valid | output | 1 | rd_data holds a buffer word |
| rd_data | output | DW | Buffer read data |
| prot_reg | output | 8 | Protection register readback |
| cfg_reg | output | 8 | Configuration register readback |
| main_valid | output | 1 | Page command forwarded to the main array |
| main_op | output | 3 | Forwarded opcode |
| main_addr | output | PA_W | Forwarded page address |

## Verification
If the sequencer holds a wrong word index or page base, the fault appears at rd_data. It shows on the first buffer read after the next page load, where a word is shifted, duplicated or stale. A lock or protect flag in the wrong state shows on the very next program or register write, as a prog_fail value that differs from the rules or a register that changed when it should not. A timer fault shows as a busy window of the wrong length. It also shows as a command that should have been ignored but was executed one cycle after the edge that accepted it.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_REGWR = 3'd1,
    OP_PGRD  = 3'd2,
    OP_PROG  = 3'd3,
    OP_LOCK  = 3'd4,
    OP_BUFWR = 3'd5,
    OP_BUFRD = 3'd6
  } sp_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_PROG
  } sq_kind_e;

  typedef enum logic [1:0] {
    PG_ID,
    PG_PARAM,
    PG_OTP,
    PG_BAD
  } pg_class_e;

  localparam int CFG_ACC  = 0;
  localparam int CFG_OTPL = 1;
  localparam int CFG_SR1L = 2;
  localparam int CFG_BUF  = 3;
  localparam int PROT_SRP0 = 6;
  localparam int PROT_SRP1 = 7;
endpackage

// File: rtl/sp_decode.sv
module sp_decode
  import sp_pkg::*;
#(
  parameter int PA_W  = 8,
  parameter int N_OTP = 10,
  localparam int OI_W = (N_OTP > 1) ? $clog2(N_OTP) : 1
) (
  input  logic [PA_W-1:0] page_addr,
  input  logic            otp_locked,
  output pg_class_e       cls,
  output logic [OI_W-1:0] otp_idx,
  output logic            load_ok,
  output logic            prog_ok
);
  localparam logic [PA_W-1:0] FIRST_OTP = PA_W'(2);
  localparam logic [PA_W-1:0] END_OTP   = PA_W'(2 + N_OTP);

  logic [PA_W-1:0] rel;
  assign rel = page_addr - FIRST_OTP;

  always_comb begin
    cls     = PG_BAD;
    otp_idx = '0;
    if (page_addr == PA_W'(0)) begin
      cls = PG_ID;
    end else if (page_addr == PA_W'(1)) begin
      cls = PG_PARAM;
    end else if (page_addr >= FIRST_OTP && page_addr < END_OTP) begin
      cls     = PG_OTP;
      otp_idx = OI_W'(rel);
    end
  end

  assign load_ok = (cls != PG_BAD);
  assign prog_ok = (cls == PG_OTP) && !otp_locked;
endmodule

// File: rtl/sp_regs.sv
module sp_regs
  import sp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       commit,
  output logic [7:0] prot_q,
  output logic [7:0] cfg_q,
  output logic       otp_locked,
  output logic       sr1_locked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q     <= 8'h00;
      cfg_q      <= 8'h00;
      otp_locked <= 1'b0;
      sr1_locked <= 1'b0;
    end else begin
      if (commit) begin
        otp_locked <= otp_locked | cfg_q[CFG_OTPL];
        sr1_locked <= sr1_locked | cfg_q[CFG_SR1L];
      end
      if (wr_en && !wr_sel && !sr1_locked) begin
        prot_q <= wr_data;
      end
      if (wr_en && wr_sel) begin
        cfg_q[CFG_ACC]  <= wr_data[CFG_ACC];
        cfg_q[CFG_OTPL] <= wr_data[CFG_OTPL] | otp_locked;
        cfg_q[CFG_SR1L] <= wr_data[CFG_SR1L] | sr1_locked;
        cfg_q[CFG_BUF]  <= wr_data[CFG_BUF];
      end
    end
  end
endmodule

// File: rtl/sp_timer.sv
module sp_timer #(
  parameter int BUSY_CYCLES = 20,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == LAST) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sp_store.sv
module sp_store
  import sp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int PAGE_WORDS  = 16,
  parameter int N_OTP       = 10,
  parameter int BUSY_CYCLES = 20,
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1),
  localparam int WI     = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1,
  localparam int OI_W   = (N_OTP > 1) ? $clog2(N_OTP) : 1,
  localparam int MDEPTH = N_OTP * PAGE_WORDS,
  localparam int MA_W   = (MDEPTH > 1) ? $clog2(MDEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  input  logic             start_load,
  input  logic             start_prog,
  input  pg_class_e        cls_in,
  input  logic [OI_W-1:0]  idx_in,
  input  logic             bwr_en,
  input  logic [WI-1:0]    bwr_col,
  input  logic [DW-1:0]    bwr_data,
  input  logic             brd_en,
  input  logic [WI-1:0]    brd_col,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] otp_mem [MDEPTH];
  logic [DW-1:0] buf_mem [PAGE_WORDS];

  initial begin
    for (int i = 0; i < MDEPTH; i++) otp_mem[i] = '1;
  end

  sq_kind_e       kind_q;
  pg_class_e      cls_q;
  logic [MA_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= SQ_IDLE;
      cls_q  <= PG_BAD;
      base_q <= '0;
    end else if (!busy) begin
      kind_q <= SQ_IDLE;
      if (start_load || start_prog) begin
        kind_q <= start_load ? SQ_LOAD : SQ_PROG;
        cls_q  <= cls_in;
        base_q <= MA_W'(int'(idx_in) * PAGE_WORDS);
      end
    end
  end

  function automatic logic [DW-1:0] rom_word(input pg_class_e c, input logic [WI-1:0] w);
    if (c == PG_ID) rom_word = DW'(8'hC0) + DW'(w);
    else            rom_word = DW'(8'hF0) - DW'(w);
  endfunction

  logic [WI-1:0]   rd_word;
  logic [WI-1:0]   widx;
  logic [MA_W-1:0] rd_addr;
  logic [MA_W-1:0] wr_addr;
  logic            wr_act;
  logic            load_we;
  logic            prog_we;
  logic [DW-1:0]   otp_q;
  logic [DW-1:0]   rom_q;
  logic [DW-1:0]   prog_wd;

  assign rd_word = WI'(cnt);
  assign widx    = WI'(cnt - CNT_W'(1));
  assign rd_addr = base_q + MA_W'(rd_word);
  assign wr_addr = base_q + MA_W'(widx);
  assign wr_act  = busy && (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(PAGE_WORDS));
  assign load_we = wr_act && (kind_q == SQ_LOAD);
  assign prog_we = wr_act && (kind_q == SQ_PROG);
  assign prog_wd = otp_q & buf_mem[widx];

  always_ff @(posedge clk) begin
    if (prog_we) otp_mem[wr_addr] <= prog_wd;
    otp_q <= otp_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    rom_q <= rom_word(cls_q, rd_word);
  end

  always_ff @(posedge clk) begin
    if (load_we) buf_mem[widx] <= (cls_q == PG_OTP) ? otp_q : rom_q;
    else if (bwr_en) buf_mem[bwr_col] <= bwr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= brd_en;
      if (brd_en) rd_data <= buf_mem[brd_col];
    end
  end
endmodule

// File: rtl/sp_region_ctrl.sv
module sp_region_ctrl
  import sp_pkg::*;
#(
  parameter int PA_W        = 8,
  parameter int DW          = 8,
  parameter int PAGE_WORDS  = 16,
  parameter int N_OTP       = 10,
  parameter int BUSY_CYCLES = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [PA_W-1:0] cmd_addr,
  input  logic [DW-1:0]   cmd_data,
  output logic            busy,
  output logic            prog_fail,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [7:0]      prot_reg,
  output logic [7:0]      cfg_reg,
  output logic            main_valid,
  output logic [2:0]      main_op,
  output logic [PA_W-1:0] main_addr
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam int WI    = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam int OI_W  = (N_OTP > 1) ? $clog2(N_OTP) : 1;

  logic             otp_locked;
  logic             sr1_locked;
  pg_class_e        cls;
  logic [OI_W-1:0]  otp_idx;
  logic             load_ok;
  logic             prog_ok;
  logic [CNT_W-1:0] cnt;

  logic go, acc, lock_ok;
  logic reg_wr, commit, start_load, start_prog, start_any;
  logic bwr_en, brd_en, fwd, refuse;
  logic [WI-1:0] col, rcol;

  assign acc     = cfg_reg[CFG_ACC];
  assign go      = cmd_valid && !busy;
  assign lock_ok = (cfg_reg[CFG_OTPL] || cfg_reg[CFG_SR1L]) &&
                   (!cfg_reg[CFG_SR1L] || (prot_reg[PROT_SRP1] && prot_reg[PROT_SRP0]));
  assign col     = WI'(cmd_addr);
  assign rcol    = (acc || cfg_reg[CFG_BUF]) ? col : '0;

  always_comb begin
    reg_wr     = 1'b0;
    commit     = 1'b0;
    start_load = 1'b0;
    start_prog = 1'b0;
    bwr_en     = 1'b0;
    brd_en     = 1'b0;
    fwd        = 1'b0;
    refuse     = 1'b0;
    if (go) begin
      case (cmd_op)
        OP_REGWR: reg_wr = 1'b1;
        OP_BUFWR: bwr_en = 1'b1;
        OP_BUFRD: brd_en = 1'b1;
        OP_PGRD: begin
          if (!acc) fwd = 1'b1;
          else if (load_ok) start_load = 1'b1;
          else refuse = 1'b1;
        end
        OP_PROG: begin
          if (!acc) fwd = 1'b1;
          else if (prog_ok) start_prog = 1'b1;
          else refuse = 1'b1;
        end
        OP_LOCK: begin
          if (!acc) fwd = 1'b1;
          else if (lock_ok) commit = 1'b1;
          else refuse = 1'b1;
        end
        default: ;
      endcase
    end
  end

  logic accepted;
  assign accepted  = reg_wr | commit | start_load | start_prog | bwr_en | brd_en | fwd | refuse;
  assign start_any = start_load | start_prog | commit;

  sp_decode #(.PA_W(PA_W), .N_OTP(N_OTP)) u_dec (
    .page_addr (cmd_addr),
    .otp_locked(otp_locked),
    .cls       (cls),
    .otp_idx   (otp_idx),
    .load_ok   (load_ok),
    .prog_ok   (prog_ok)
  );

  sp_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .wr_sel    (cmd_addr[0]),
    .wr_data   (cmd_data[7:0]),
    .commit    (commit),
    .prot_q    (prot_reg),
    .cfg_q     (cfg_reg),
    .otp_locked(otp_locked),
    .sr1_locked(sr1_locked)
  );

  sp_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .start(start_any),
    .busy (busy),
    .cnt  (cnt)
  );

  sp_store #(
    .DW(DW), .PAGE_WORDS(PAGE_WORDS), .N_OTP(N_OTP), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .cnt       (cnt),
    .start_load(start_load),
    .start_prog(start_prog),
    .cls_in    (cls),
    .idx_in    (otp_idx),
    .bwr_en    (bwr_en),
    .bwr_col   (col),
    .bwr_data  (cmd_data),
    .brd_en    (brd_en),
    .brd_col   (rcol),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_fail  <= 1'b0;
      main_valid <= 1'b0;
      main_op    <= 3'd0;
      main_addr  <= '0;
    end else begin
      if (accepted) prog_fail <= refuse;
      main_valid <= fwd;
      if (fwd) begin
        main_op   <= cmd_op;
        main_addr <= cmd_addr;
      end
    end
  end
endmodule

// File: rtl/sp_region_ctrl_chk.sv
module sp_region_ctrl_chk #(
  parameter int BUSY_CYCLES = 20
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       prog_fail,
  input logic       rd_valid,
  input logic       main_valid,
  input logic [7:0] cfg_reg,
  input logic [7:0] prot_reg,
  input logic       otp_locked,
  input logic       sr1_locked
);
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (busy) run_len <= run_len + 16'd1;
    else run_len <= '0;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !prog_fail && !rd_valid && !main_valid && cfg_reg == 8'h00));

  assert_fwd_main_mode_R2: assert property (@(posedge clk) disable iff (rst)
    main_valid |-> (!cfg_reg[0] && !busy));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == 16'(BUSY_CYCLES)));

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cfg_reg) && $stable(prot_reg) && !rd_valid && !main_valid));

  assert_otp_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    otp_locked |=> otp_locked);

  assert_prot_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    sr1_locked |=> ($stable(prot_reg) && sr1_locked));

  assert_lock_reads_one_R11: assert property (@(posedge clk) disable iff (rst)
    (otp_locked || sr1_locked) |-> ((!otp_locked || cfg_reg[1]) && (!sr1_locked || cfg_reg[2])));
endmodule

bind sp_region_ctrl sp_region_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .prog_fail (prog_fail),
  .rd_valid  (rd_valid),
  .main_valid(main_valid),
  .cfg_reg   (cfg_reg),
  .prot_reg  (prot_reg),
  .otp_locked(otp_locked),
  .sr1_locked(sr1_locked)
);

// File: tb/sp_region_ctrl_test.sv
module sp_region_ctrl_test;
  import sp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int NO = 10;
  localparam int BC = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_addr = 8'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       busy, prog_fail, rd_valid, main_valid;
  logic [7:0] rd_data, prot_reg, cfg_reg, main_addr;
  logic [2:0] main_op;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_mem [NO][PW];

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_region_ctrl #(.PA_W(8), .DW(8), .PAGE_WORDS(PW), .N_OTP(NO), .BUSY_CYCLES(BC)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .busy(busy), .prog_fail(prog_fail), .rd_valid(rd_valid),
    .rd_data(rd_data), .prot_reg(prot_reg), .cfg_reg(cfg_reg), .main_valid(main_valid),
    .main_op(main_op), .main_addr(main_addr)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] col, input logic [7:0] exp);
    cmd(OP_BUFRD, col, 8'h00);
    check(tag, {rd_valid, rd_data}, {1'b1, exp});
  endtask

  function automatic logic [7:0] pat(input int p, input int w, input int k);
    return 8'((p * 16 + w) * 29 + k * 83 + 7);
  endfunction

  function automatic logic [7:0] page_word(input int a, input int w);
    if (a == 0) return 8'(8'hC0 + w);
    if (a == 1) return 8'(8'hF0 - w);
    return exp_mem[a-2][w];
  endfunction

  task automatic verify_page(input string tag, input int a);
    cmd(OP_PGRD, 8'(a), 8'h00);
    wait_idle();
    for (int w = 0; w < PW; w++) rd_chk(tag, 8'(w), page_word(a, w));
  endtask

  task automatic program_page(input int p, input int k);
    for (int w = 0; w < PW; w++) cmd(OP_BUFWR, 8'(w), pat(p, w, k));
    cmd(OP_PROG, 8'(p + 2), 8'h00);
    check("R6 accept", {busy, prog_fail}, 2'b10);
    wait_idle();
    for (int w = 0; w < PW; w++) exp_mem[p][w] = exp_mem[p][w] & pat(p, w, k);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    int n;
    for (int p = 0; p < NO; p++) for (int w = 0; w < PW; w++) exp_mem[p][w] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 status", {busy, prog_fail, rd_valid, main_valid}, 4'b0000);
    check("R1 regs", {cfg_reg, prot_reg, rd_data}, 24'h0);

    // R2 forwarding outside access mode
    cmd(OP_PGRD, 8'h05, 8'h00);
    check("R2 load fwd", {main_valid, main_op, main_addr, busy}, {1'b1, 3'd2, 8'h05, 1'b0});
    cmd(OP_PROG, 8'h33, 8'h00);
    check("R2 prog fwd", {main_valid, main_op, main_addr, busy}, {1'b1, 3'd3, 8'h33, 1'b0});
    cmd(OP_LOCK, 8'h00, 8'h00);
    check("R2 lock fwd", {main_valid, main_op, busy}, {1'b1, 3'd4, 1'b0});

    // R13 buffer column handling
    cmd(OP_BUFWR, 8'h03, 8'h5A);
    cmd(OP_BUFWR, 8'h00, 8'h11);
    rd_chk("R13 col forced 0", 8'h03, 8'h11);
    cmd(OP_REGWR, 8'h01, 8'h08);
    check("R13 cfg", cfg_reg, 8'h08);
    rd_chk("R13 col used", 8'h03, 8'h5A);
    cmd(OP_REGWR, 8'h01, 8'h01);
    check("R13 cfg acc", cfg_reg, 8'h01);
    rd_chk("R13 col in access", 8'h03, 8'h5A);

    // R7 busy length on a load
    cmd(OP_PGRD, 8'h00, 8'h00);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R7 load busy", n, BC);

    // R3 and R6: all pages, erased content
    for (int a = 0; a < NO + 2; a++) verify_page("R3 page", a);

    // R8 commands ignored while busy
    cmd(OP_PGRD, 8'h01, 8'h00);
    cmd(OP_REGWR, 8'h01, 8'h00);
    check("R8 reg ignored", {cfg_reg, busy}, {8'h01, 1'b1});
    cmd(OP_BUFRD, 8'h00, 8'h00);
    check("R8 read ignored", rd_valid, 0);
    cmd(OP_PGRD, 8'h00, 8'h00);
    wait_idle();
    rd_chk("R8 load ignored", 8'h02, 8'hEE);

    // R4 invalid addresses, R12 flag clearing
    for (int a = NO + 2; a < 256; a++) begin
      cmd(OP_PGRD, 8'(a), 8'h00);
      check("R4 load bad", {busy, prog_fail}, 2'b01);
      cmd(OP_BUFRD, 8'h00, 8'h00);
      check("R12 clear", prog_fail, 0);
      cmd(OP_PROG, 8'(a), 8'h00);
      check("R4 prog bad", {busy, prog_fail}, 2'b01);
      cmd(OP_REGWR, 8'h01, 8'h01);
      check("R12 clear reg", prog_fail, 0);
    end

    // R5 factory pages read only
    for (int w = 0; w < PW; w++) cmd(OP_BUFWR, 8'(w), 8'h00);
    cmd(OP_PROG, 8'h00, 8'h00);
    check("R5 id prog", {busy, prog_fail}, 2'b01);
    cmd(OP_PROG, 8'h01, 8'h00);
    check("R5 param prog", {busy, prog_fail}, 2'b01);
    verify_page("R5 id intact", 0);
    verify_page("R5 param intact", 1);

    // R6 programming is AND, two passes per page
    for (int p = 0; p < NO; p++) begin
      program_page(p, 0);
      program_page(p, 1);
    end
    for (int p = 0; p < NO; p++) verify_page("R6 content", p + 2);

    // R14 lock with no lock bit set
    cmd(OP_LOCK, 8'h00, 8'h00);
    check("R14 no bits", {busy, prog_fail}, 2'b01);

    // R10 negative and R11 before commit
    cmd(OP_REGWR, 8'h01, 8'h05);
    cmd(OP_LOCK, 8'h00, 8'h00);
    check("R10 srp missing", {busy, prog_fail}, 2'b01);
    cmd(OP_REGWR, 8'h00, 8'h3F);
    check("R10 prot writable", prot_reg, 8'h3F);
    cmd(OP_REGWR, 8'h01, 8'h01);
    check("R11 clear before commit", cfg_reg, 8'h01);

    // R10 positive commit
    cmd(OP_REGWR, 8'h00, 8'hC5);
    cmd(OP_REGWR, 8'h01, 8'h05);
    cmd(OP_LOCK, 8'h00, 8'h00);
    check("R10 commit", {busy, prog_fail}, 2'b10);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R7 lock busy", n, BC);
    cmd(OP_REGWR, 8'h00, 8'h00);
    check("R10 prot frozen", prot_reg, 8'hC5);
    cmd(OP_REGWR, 8'h01, 8'h01);
    check("R11 sr1 stays", cfg_reg, 8'h05);

    // R9 otp lock
    program_page(3, 2);
    cmd(OP_REGWR, 8'h01, 8'h03);
    check("R9 cfg", cfg_reg, 8'h07);
    cmd(OP_LOCK, 8'h00, 8'h00);
    check("R9 commit", {busy, prog_fail}, 2'b10);
    wait_idle();
    cmd(OP_REGWR, 8'h01, 8'h01);
    check("R11 otp stays", cfg_reg, 8'h07);
    for (int w = 0; w < PW; w++) cmd(OP_BUFWR, 8'(w), 8'h00);
    for (int p = 0; p < NO; p++) begin
      cmd(OP_PROG, 8'(p + 2), 8'h00);
      check("R9 prog locked", {busy, prog_fail}, 2'b01);
    end
    verify_page("R9 content kept", 2);
    verify_page("R9 content kept", 5);
    verify_page("R9 content kept", 11);

    // leave access mode, page commands forward again
    cmd(OP_REGWR, 8'h01, 8'h00);
    check("R11 exit cfg", cfg_reg, 8'h06);
    cmd(OP_PGRD, 8'h02, 8'h00);
    check("R2 after exit", {main_valid, main_op, main_addr, busy}, {1'b1, 3'd2, 8'h02, 1'b0});

    finish_up();
  end
endmodule